// File: doc/BRIEF.md
# CRC-Protected Host Packet Sender

This block turns each new sensor frame into a fixed 42-byte packet and offers that packet to a host processor through an SPI slave port. A frame update carries fifteen 16-bit payload words, a 32-bit capture timestamp and two 16-bit encoder counts. From these the block builds a staging copy of the packet. A serial engine then appends a reflected CRC-32, folding one byte per clock.

Once the CRC is complete, the block looks at the synchronized host chip select. If the host is idle, the staging copy moves into a separate sending buffer and the data-ready output rises. The host then clocks the packet out. If the host is in the middle of a read, the sending buffer is left alone and an overrun counter advances. A packet in flight is therefore never torn by newer data.

The host side runs in SPI mode with clock idle low and sampling on the falling edge, using 8-bit frames with the most significant bit first. Everything the host shifts in is captured and otherwise ignored.

Top module: `hps_host_sender`

## Requirements
- R1: After reset, `host_rdy` is 0, `overrun_cnt` is 0 and `spi_miso` is 0.
- R2: Packet byte order:
  - Bytes 0 to 29 hold payload word k (bits [16k+15:16k] of `frame_words`), with its low byte at byte 2k and its high byte at byte 2k+1.
  - Bytes 30 to 33 hold `frame_stamp`, least significant byte first.
  - Bytes 34 and 35 hold `enc_a`, least significant byte first.
  - Bytes 36 and 37 hold `enc_b`, least significant byte first.
- R3: Bytes 38 to 41 hold a CRC, least significant byte first. It is the reflected CRC-32 with polynomial 0xEDB88320 and start value 0xFFFFFFFF, taken over bytes 0 to 37 in order, with no final inversion.
- R4: A packet finishes its CRC 39 clocks after the `frame_valid` sample. If the synchronized `spi_csn` is high at that point, the packet is copied to the sending buffer and `host_rdy` is 1 on the next clock.
- R5: If the synchronized `spi_csn` is low when a packet finishes, nothing is copied, `host_rdy` keeps its value, and `overrun_cnt` increases by one (wrapping).
- R6: Every `frame_valid` pulse rebuilds the staging packet. A frame arriving before the previous packet has finished replaces it, and only the newest packet is judged (no overrun is counted for the replaced one).
- R7: The SPI slave has the following behaviour:
  - `spi_csn` is active low.
  - `spi_miso` takes the next bit after each rising `spi_sck` edge, so the host samples it on the falling edge.
  - Bits go out most significant first, eight per byte, starting at byte 0 of the sending buffer.
- R8: `host_rdy` falls once the last falling edge of byte 41 has been seen within one selected transfer.
- R9: Raising `spi_csn` before byte 41 completes returns the byte pointer to byte 0 and leaves `host_rdy` high.
- R10: Data on `spi_mosi` has no effect on the bytes sent on `spi_miso`.
- R11: While `spi_csn` is low, the sending buffer is not changed, even if new frames arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle pulse: new frame on the frame inputs |
| frame_words | input | N_WORDS*WORD_W (240) | Payload words, word k at bits [16k+15:16k] |
| frame_stamp | input | STAMP_W (32) | Capture timestamp of the frame |
| enc_a | input | ENC_W (16) | First encoder count |
| enc_b | input | ENC_W (16) | Second encoder count |
| spi_sck | input | 1 | Host SPI clock, asynchronous |
| spi_mosi | input | 1 | Host data in, asynchronous |
| spi_csn | input | 1 | Host chip select, active low, asynchronous |
| spi_miso | output | 1 | Serial packet data to the host |
| host_rdy | output | 1 | A fresh packet waits in the sending buffer |
| overrun_cnt | output | CNT_W (16) | Packets dropped because the host was selected |

## Verification
The two functions that overlap are the staging path (frame capture, CRC folding and the arm decision) and the slave shifter draining the sending buffer. A new frame can finish its CRC while the host is partway through clocking out the previous packet.

The bench provokes this overlap directly. It pauses a read after ten bytes with chip select still low, injects a new frame, and waits past the arm decision. It then checks three things:
- `overrun_cnt` has stepped by one.
- `host_rdy` is still high.
- The remaining 32 bytes are those of the older packet.

It then checks that `host_rdy` falls only when byte 41 ends. Back-to-back frames inside one CRC window are also judged, to confirm that only the newer one is armed.

// File: rtl/hps_pkg.sv
package hps_pkg;

  // Reflected CRC-32 constants
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  // Edge events detected on a synchronized line
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Fold one byte into a reflected CRC-32 register (LSB-first processing)
  function automatic logic [31:0] crc32_fold_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], din[g]};
    end

    assign dout[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/hps_stage.sv
module hps_stage
  import hps_pkg::*;
#(
  parameter int BODY_BYTES = 38
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_valid,
  input  logic [BODY_BYTES*8-1:0]     body,
  output logic [(BODY_BYTES+4)*8-1:0] pkt,
  output logic                        done
);

  localparam int              IDX_W    = $clog2(BODY_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BODY_BYTES - 1);

  logic [BODY_BYTES*8-1:0] body_q;
  logic [31:0]             crc_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q;
  logic                    done_q;
  logic [7:0]              cur_byte;

  assign cur_byte = body_q[int'(idx_q)*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q <= '0;
      crc_q  <= CRC_SEED;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (frame_valid) begin
      // A new frame always restarts staging, discarding any partial CRC
      body_q <= body;
      crc_q  <= CRC_SEED;
      idx_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        crc_q <= crc32_fold_byte(crc_q, cur_byte);
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // CRC sits above the body so its low byte becomes the first CRC byte
  assign pkt  = {crc_q, body_q};
  assign done = done_q;

endmodule

// File: rtl/hps_spi_out.sv
module hps_spi_out
  import hps_pkg::*;
#(
  parameter int PKT_BYTES = 42
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck_s,
  input  logic                   mosi_s,
  input  logic                   csn_s,
  input  logic                   load,
  input  logic [PKT_BYTES*8-1:0] pkt,
  output logic                   miso,
  output logic                   rdy,
  output logic                   byte_done,
  output logic                   xfer_done,
  output logic [PKT_BYTES*8-1:0] send_buf,
  output logic [7:0]             rx_byte
);

  localparam int               PTR_W    = $clog2(PKT_BYTES);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PKT_BYTES - 1);

  logic                   sck_d, csn_d;
  edge_t                  sck_e, cs_e;
  logic                   active;
  logic [PKT_BYTES*8-1:0] send_q;
  logic [2:0]             bit_q;
  logic [PTR_W-1:0]       ptr_q;
  logic [6:0]             rx_sh_q;
  logic [7:0]             rx_q;
  logic                   miso_q;
  logic                   rdy_q;
  logic [7:0]             cur_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
    end
  end

  assign sck_e.rise = sck_s & ~sck_d;
  assign sck_e.fall = ~sck_s & sck_d;
  assign cs_e.fall  = ~csn_s & csn_d;
  assign cs_e.rise  = csn_s & ~csn_d;
  assign active     = ~csn_s;

  assign cur_byte  = send_q[int'(ptr_q)*8 +: 8];
  assign byte_done = active & ~cs_e.fall & sck_e.fall & (bit_q == 3'd7);
  assign xfer_done = byte_done & (ptr_q == LAST_PTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q  <= '0;
      bit_q   <= '0;
      ptr_q   <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      miso_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      if (load) send_q <= pkt;

      if (cs_e.fall || cs_e.rise) begin
        // Select or early deselect: start over at byte 0, bit 7
        bit_q <= '0;
        ptr_q <= '0;
      end else if (active) begin
        if (sck_e.rise) miso_q <= cur_byte[3'd7 - bit_q];
        if (sck_e.fall) begin
          rx_sh_q <= {rx_sh_q[5:0], mosi_s};
          bit_q   <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            rx_q  <= {rx_sh_q, mosi_s};
            ptr_q <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
          end
        end
      end

      if (load)           rdy_q <= 1'b1;
      else if (xfer_done) rdy_q <= 1'b0;
    end
  end

  assign miso     = miso_q;
  assign rdy      = rdy_q;
  assign send_buf = send_q;
  assign rx_byte  = rx_q;

endmodule

// File: rtl/hps_host_sender.sv
module hps_host_sender
  import hps_pkg::*;
#(
  parameter int N_WORDS     = 15,
  parameter int WORD_W      = 16,
  parameter int STAMP_W     = 32,
  parameter int ENC_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_valid,
  input  logic [N_WORDS*WORD_W-1:0] frame_words,
  input  logic [STAMP_W-1:0]        frame_stamp,
  input  logic [ENC_W-1:0]          enc_a,
  input  logic [ENC_W-1:0]          enc_b,
  input  logic                      spi_sck,
  input  logic                      spi_mosi,
  input  logic                      spi_csn,
  output logic                      spi_miso,
  output logic                      host_rdy,
  output logic [CNT_W-1:0]          overrun_cnt
);

  localparam int BODY_W     = N_WORDS*WORD_W + STAMP_W + 2*ENC_W;
  localparam int BODY_BYTES = BODY_W / 8;
  localparam int PKT_BYTES  = BODY_BYTES + 4;

  // Every field is laid out little-endian; lower fields sit at lower bytes
  function automatic logic [BODY_W-1:0] pack_body(
      input logic [N_WORDS*WORD_W-1:0] words,
      input logic [STAMP_W-1:0]        stamp,
      input logic [ENC_W-1:0]          ea,
      input logic [ENC_W-1:0]          eb);
    return {eb, ea, stamp, words};
  endfunction

  // Named internal events (observed by the bound checker)
  logic [2:0]             sync_lvl;
  logic                   cs_idle;
  logic                   stg_done;
  logic                   arm_ok;
  logic                   arm_block;
  logic                   byte_done;
  logic                   xfer_done;
  logic [PKT_BYTES*8-1:0] stage_pkt;
  logic [PKT_BYTES*8-1:0] send_buf;
  logic [7:0]             rx_byte;
  logic [CNT_W-1:0]       ovr_q;

  hps_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .INIT   (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({spi_csn, spi_mosi, spi_sck}),
    .dout  (sync_lvl)
  );

  assign cs_idle = sync_lvl[2];

  hps_stage #(
    .BODY_BYTES (BODY_BYTES)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .body        (pack_body(frame_words, frame_stamp, enc_a, enc_b)),
    .pkt         (stage_pkt),
    .done        (stg_done)
  );

  assign arm_ok    = stg_done & cs_idle;
  assign arm_block = stg_done & ~cs_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= '0;
    else if (arm_block) ovr_q <= ovr_q + 1'b1;
  end

  hps_spi_out #(
    .PKT_BYTES (PKT_BYTES)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sync_lvl[0]),
    .mosi_s    (sync_lvl[1]),
    .csn_s     (sync_lvl[2]),
    .load      (arm_ok),
    .pkt       (stage_pkt),
    .miso      (spi_miso),
    .rdy       (host_rdy),
    .byte_done (byte_done),
    .xfer_done (xfer_done),
    .send_buf  (send_buf),
    .rx_byte   (rx_byte)
  );

  assign overrun_cnt = ovr_q;

endmodule

// File: rtl/hps_host_sender_chk.sv
module hps_host_sender_chk #(
  parameter int CNT_W = 16,
  parameter int PKT_W = 336
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_rdy,
  input logic [CNT_W-1:0] overrun_cnt,
  input logic             arm_ok,
  input logic             arm_block,
  input logic             stg_done,
  input logic             byte_done,
  input logic             xfer_done,
  input logic             cs_idle,
  input logic [PKT_W-1:0] send_buf,
  input logic [7:0]       rx_byte
);

  AST_RDY_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdy) |-> $past(arm_ok)); // R4

  AST_ARM_RAISES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> host_rdy); // R4

  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_block |=> overrun_cnt == CNT_W'($past(overrun_cnt) + 1'b1)); // R5

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_block |=> $stable(overrun_cnt)); // R5

  AST_STG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stg_done |=> !stg_done); // R6

  AST_DONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !cs_idle); // R7

  AST_RDY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rdy) |-> $past(xfer_done)); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_byte)); // R10

  AST_SEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && !$past(cs_idle)) |-> $stable(send_buf)); // R11

endmodule

bind hps_host_sender hps_host_sender_chk #(
  .CNT_W (CNT_W),
  .PKT_W (PKT_BYTES*8)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rdy    (host_rdy),
  .overrun_cnt (overrun_cnt),
  .arm_ok      (arm_ok),
  .arm_block   (arm_block),
  .stg_done    (stg_done),
  .byte_done   (byte_done),
  .xfer_done   (xfer_done),
  .cs_idle     (cs_idle),
  .send_buf    (send_buf),
  .rx_byte     (rx_byte)
);

// File: tb/hps_host_sender_tb_top.sv
module hps_host_sender_tb_top;

  localparam int          NW   = 15;
  localparam int          PKT  = 42;
  localparam int          HP   = 8;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           frame_valid;
  logic [NW*16-1:0] frame_words;
  logic [31:0]    frame_stamp;
  logic [15:0]    enc_a, enc_b;
  logic           spi_sck, spi_mosi, spi_csn;
  logic           spi_miso, host_rdy;
  logic [15:0]    overrun_cnt;

  hps_host_sender dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_words (frame_words),
    .frame_stamp (frame_stamp),
    .enc_a       (enc_a),
    .enc_b       (enc_b),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_csn     (spi_csn),
    .spi_miso    (spi_miso),
    .host_rdy    (host_rdy),
    .overrun_cnt (overrun_cnt)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_pkt [PKT];
  logic [7:0]  got     [PKT];
  logic [15:0] ovr_ref;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bit-serial reference CRC: feed one data bit at a time, LSB of each byte first
  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 38; i++) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ exp_pkt[i][j];
        c  = c >> 1;
        if (fb) c = c ^ POLY;
      end
    end
    return c;
  endfunction

  // Expected packet from the current frame inputs (R2, R3)
  task automatic build_expected();
    logic [15:0] w;
    logic [31:0] crc;
    for (int i = 0; i < 30; i++) begin
      w = frame_words[16*(i/2) +: 16];
      exp_pkt[i] = (i % 2 == 1) ? w[15:8] : w[7:0];
    end
    for (int i = 0; i < 4; i++) exp_pkt[30+i] = frame_stamp[8*i +: 8];
    exp_pkt[34] = enc_a[7:0];
    exp_pkt[35] = enc_a[15:8];
    exp_pkt[36] = enc_b[7:0];
    exp_pkt[37] = enc_b[15:8];
    crc = ref_crc();
    for (int i = 0; i < 4; i++) exp_pkt[38+i] = crc[8*i +: 8];
  endtask

  task automatic rand_frame();
    for (int k = 0; k < NW; k++) frame_words[16*k +: 16] = 16'($urandom);
    frame_stamp = $urandom;
    enc_a       = 16'($urandom);
    enc_b       = 16'($urandom);
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk);
    spi_csn = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_high();
    wait_clk(HP);
    spi_csn = 1'b1;
    wait_clk(HP);
  endtask

  // Host mode: drive SCK high (slave updates MISO), sample before the falling edge
  task automatic xfer_bytes(input int first, input int count, input int mode);
    logic [7:0] pat;
    for (int b = first; b < first + count; b++) begin
      case (mode)
        0:       pat = 8'h00;
        1:       pat = 8'hFF;
        default: pat = 8'($urandom);
      endcase
      for (int k = 7; k >= 0; k--) begin
        spi_sck  = 1'b1;
        spi_mosi = pat[k];
        wait_clk(HP);
        got[b][k] = spi_miso;
        spi_sck = 1'b0;
        wait_clk(HP);
      end
    end
  endtask

  task automatic compare(input int first, input int count, input string tag);
    for (int i = first; i < first + count; i++) begin
      if (tag != "")     chk($sformatf("%s byte %0d", tag, i), 64'(got[i]), 64'(exp_pkt[i]));
      else if (i < 38)   chk($sformatf("R2 byte %0d", i), 64'(got[i]), 64'(exp_pkt[i]));
      else               chk($sformatf("R3 crc byte %0d", i), 64'(got[i]), 64'(exp_pkt[i]));
    end
  endtask

  // Arm a packet with the host idle and check data-ready (R4)
  task automatic arm_current();
    pulse_frame();
    build_expected();
    wait_clk(60);
    chk("R4 host_rdy after arm", 64'(host_rdy), 64'd1);
  endtask

  task automatic full_read(input int mode, input string tag);
    cs_low();
    xfer_bytes(0, PKT, mode);
    cs_high();
    compare(0, PKT, tag);
    chk("R8 host_rdy after 42 bytes", 64'(host_rdy), 64'd0);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v      = $urandom(32'd424242);
    rst_n       = 1'b0;
    frame_valid = 1'b0;
    frame_words = '0;
    frame_stamp = '0;
    enc_a       = '0;
    enc_b       = '0;
    spi_sck     = 1'b0;
    spi_mosi    = 1'b0;
    spi_csn     = 1'b1;
    ovr_ref     = '0;
    wait_clk(5);

    // R1: reset state
    chk("R1 host_rdy reset", 64'(host_rdy), 64'd0);
    chk("R1 overrun reset", 64'(overrun_cnt), 64'd0);
    chk("R1 miso reset", 64'(spi_miso), 64'd0);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R1 host_rdy idle", 64'(host_rdy), 64'd0);

    // Directed: distinct byte values to expose order (R2, R3, R7)
    for (int k = 0; k < NW; k++) frame_words[16*k +: 16] = {8'(8'h80 + k), 8'(k + 1)};
    frame_stamp = 32'hA1B2C3D4;
    enc_a       = 16'h1357;
    enc_b       = 16'hFEDC;
    arm_current();
    full_read(0, "");
    chk("R7 first byte MSB first", 64'(got[0]), 64'h01);

    // R10: re-read the same sending buffer with opposite host data
    full_read(1, "R10");

    // Constrained random frames with random host data
    for (int it = 0; it < 4; it++) begin
      rand_frame();
      arm_current();
      full_read(2, "");
    end

    // R5 / R11: frame lands while the host is mid-transfer
    rand_frame();
    arm_current();
    cs_low();
    xfer_bytes(0, 10, 2);
    rand_frame();
    pulse_frame();
    wait_clk(60);
    ovr_ref = ovr_ref + 16'd1;
    chk("R5 overrun step", 64'(overrun_cnt), 64'(ovr_ref));
    chk("R5 host_rdy kept", 64'(host_rdy), 64'd1);
    xfer_bytes(10, PKT - 10, 2);
    cs_high();
    compare(0, 10, "");
    compare(10, PKT - 10, "R11");
    chk("R8 host_rdy after split read", 64'(host_rdy), 64'd0);

    // R9: early deselect keeps data-ready and restarts at byte 0
    rand_frame();
    arm_current();
    cs_low();
    xfer_bytes(0, 5, 2);
    cs_high();
    chk("R9 host_rdy after early deselect", 64'(host_rdy), 64'd1);
    full_read(2, "R9");

    // R6: two frames inside one CRC window, only the newer is armed
    rand_frame();
    pulse_frame();
    wait_clk(10);
    rand_frame();
    arm_current();
    chk("R6 no overrun for replaced frame", 64'(overrun_cnt), 64'(ovr_ref));
    full_read(2, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule